// File: doc/BRIEF.md
# Paged Host Register File for a Simple Ethernet Controller

This block is the byte-wide register front end that a host processor sees when it drives a small Ethernet controller. It holds the command register and the ring-buffer page pointers. It also holds the transmit and remote-DMA counters, the station address bytes, the multicast hash mask, and the interrupt status and mask pair. A 4-bit offset selects a register. Offset 0 always reaches the command register. For every other offset, the top two command bits choose one of four pages, so the same offset means different storage on different pages.

Some command writes have side effects. Starting the engine retires the reset-complete flag. A remote read or write asked for with a zero remote count completes at once. A transmit request raises a one-cycle send pulse to an external packet sender, records a good transmit status and flags transmit-OK. The transmit bit then reads back as zero.

Receive-side logic reports its own events through a set-vector input. A single level interrupt output summarises the status bits that the mask enables.

Top module: `nic_regfile`

## Requirements
- R1: A synchronous reset makes the command register read 0x01, the status register 0x80 and the mask 0x00. Every other register reads 0x00, and irq and send_req are low.
- R2: Offset 0 reads and writes the command register on every page. Any other offset selects the register {cmd[7:6], offset}. Reads of an unmapped combination, including all of page 3, return 0x00, and writes to them change nothing.
- R3: irq is high exactly when (status AND mask AND 0x7F) is nonzero, one cycle after the write or event that changes either register. Status bit 7 never raises irq.
- R4: Status bits are 0 rx-ok, 1 tx-ok, 2 rx-error, 3 tx-error, 4 ring-overwrite, 5 counter-attention, 6 dma-complete and 7 reset-complete. A write to page-0 offset 7 clears each of bits [6:0] where the written byte holds a 1, and it never touches bit 7. Any bit of the rx_events input sets the matching status bit, and a set wins over a clear in the same cycle.
- R5: A command write with bit 0 (stop) clear clears status bit 7. If that write also has bit 3 (remote read) or bit 4 (remote write) set while the 16-bit remote count is zero, it sets status bit 6.
- R6: A command write with bit 2 (transmit) set and bit 0 clear has four effects. send_req is high for the next cycle only. Page-0 offset 4 then reads 0x01. Status bit 1 is set. The stored command has bit 2 cleared. When bit 0 is set, the write is stored as given, with no side effects.
- R7: The 16-bit registers are written one byte at a time on page 0: transmit count at offsets 5 (low) and 6 (high), remote start at 8 and 9, remote count at 10 and 11. Each byte write keeps the other byte. The remote start reads back at 8 and 9, and the transmit count appears on tx_count.
- R8: On page 0, offset 1 writes the ring start page and offset 2 the ring stop page. Reads at those offsets return 0x00, and the values read back on page 2 at offsets 1 and 2. Offset 3 (boundary) reads and writes. Offset 4 writes the transmit page, which appears on tx_page. Offset 15 writes the mask.
- R9: On page 1, offsets 1 to 6 are the station address bytes, offset 7 is the current receive page and offsets 8 to 15 are the multicast mask bytes. All of them read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Write strobe for host_addr / host_wdata |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| rx_events | input | 8 | Status set vector from receive-side logic |
| irq | output | 1 | Level interrupt |
| send_req | output | 1 | One-cycle request to the packet sender |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |

## Verification
The status register can be written by the host and set by an event input in the same cycle. A command write can also set bits 1, 6 or clear bit 7 in the same cycle that rx_events carries the same bit. The bench provokes this on purpose by clearing bit 0 while rx_events[0] is high, and by sending rx_events[7] after a start command. It also overlaps random events with random writes. A cycle-level reference model in the bench applies clear-then-set ordering, and it judges the status read-back and irq after every clock.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int DW    = 8;
  localparam int OFS_W = 4;
  localparam int PG_W  = 2;
  localparam int KEY_W = OFS_W + PG_W;

  // command bits
  localparam int CB_STOP   = 0;
  localparam int CB_START  = 1;
  localparam int CB_TRANS  = 2;
  localparam int CB_RREAD  = 3;
  localparam int CB_RWRITE = 4;
  localparam int CB_NODMA  = 5;

  // status bits
  localparam int SB_TXOK  = 1;
  localparam int SB_DMA   = 6;
  localparam int SB_RESET = 7;

  localparam logic [DW-1:0] CMD_RST  = 8'h01;
  localparam logic [DW-1:0] ISR_RST  = 8'h80;
  localparam logic [DW-1:0] IRQ_BITS = 8'h7F;
  localparam logic [DW-1:0] TSR_GOOD = 8'h01;

  // effective register keys {page, offset}
  localparam logic [KEY_W-1:0] K_PSTART  = 6'h01;
  localparam logic [KEY_W-1:0] K_PSTOP   = 6'h02;
  localparam logic [KEY_W-1:0] K_BND     = 6'h03;
  localparam logic [KEY_W-1:0] K_TXPG    = 6'h04;
  localparam logic [KEY_W-1:0] K_TCNT_L  = 6'h05;
  localparam logic [KEY_W-1:0] K_TCNT_H  = 6'h06;
  localparam logic [KEY_W-1:0] K_STAT    = 6'h07;
  localparam logic [KEY_W-1:0] K_RSA_L   = 6'h08;
  localparam logic [KEY_W-1:0] K_RSA_H   = 6'h09;
  localparam logic [KEY_W-1:0] K_RCNT_L  = 6'h0A;
  localparam logic [KEY_W-1:0] K_RCNT_H  = 6'h0B;
  localparam logic [KEY_W-1:0] K_MASK    = 6'h0F;
  localparam logic [KEY_W-1:0] K_STN0    = 6'h11;
  localparam logic [KEY_W-1:0] K_CURPG   = 6'h17;
  localparam logic [KEY_W-1:0] K_MC0     = 6'h18;
  localparam logic [KEY_W-1:0] K_RPSTART = 6'h21;
  localparam logic [KEY_W-1:0] K_RPSTOP  = 6'h22;

  function automatic logic [KEY_W-1:0] f_key(input logic [PG_W-1:0] pg,
                                              input logic [OFS_W-1:0] ofs);
    return {pg, ofs};
  endfunction

  function automatic logic [15:0] f_merge_byte(input logic [15:0] old,
                                               input logic [7:0] b,
                                               input logic hi);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic f_irq_pending(input logic [DW-1:0] stat,
                                         input logic [DW-1:0] mask);
    return |(stat & mask & IRQ_BITS);
  endfunction

  function automatic logic [DW-1:0] f_status_next(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] clr,
                                                  input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          rcnt_zero,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] tsr_q,
  output logic          send_req,
  output logic          run_ev,
  output logic          dma_done_ev,
  output logic          tx_done_ev
);
  assign run_ev      = cmd_wr && !wdata[CB_STOP];
  assign dma_done_ev = run_ev && (wdata[CB_RREAD] || wdata[CB_RWRITE]) && rcnt_zero;
  assign tx_done_ev  = run_ev && wdata[CB_TRANS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_RST;
      tsr_q    <= '0;
      send_req <= 1'b0;
    end else begin
      send_req <= tx_done_ev;
      if (cmd_wr) begin
        cmd_q <= wdata;
        if (tx_done_ev) cmd_q[CB_TRANS] <= 1'b0;
      end
      if (tx_done_ev) tsr_q <= TSR_GOOD;
    end
  end

  assert_tx_selfclear_R6: assert property (@(posedge clk) disable iff (rst)
    tx_done_ev |=> (send_req && !cmd_q[CB_TRANS] && tsr_q == TSR_GOOD));

  assert_stop_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[CB_STOP]) |=> (!send_req && cmd_q == $past(wdata)));
endmodule

// File: rtl/nic_status_irq.sv
module nic_status_irq
  import nic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stat_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  input  logic          run_ev,
  input  logic          dma_done_ev,
  input  logic          tx_done_ev,
  input  logic [DW-1:0] ev_set,
  output logic [DW-1:0] isr_q,
  output logic [DW-1:0] imr_q,
  output logic          irq
);
  logic [DW-1:0] clr_mask, set_mask;

  always_comb begin
    clr_mask = stat_wr ? (wdata & IRQ_BITS) : '0;
    if (run_ev) clr_mask[SB_RESET] = 1'b1;
    set_mask = ev_set;
    if (dma_done_ev) set_mask[SB_DMA]  = 1'b1;
    if (tx_done_ev)  set_mask[SB_TXOK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= ISR_RST;
      imr_q <= '0;
    end else begin
      isr_q <= f_status_next(isr_q, clr_mask, set_mask);
      if (mask_wr) imr_q <= wdata;
    end
  end

  assign irq = f_irq_pending(isr_q, imr_q);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && set_mask == '0) |=> ((isr_q & $past(wdata) & IRQ_BITS) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_set != '0) |=> ((isr_q & $past(ev_set)) == $past(ev_set)));

  assert_bit7_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !run_ev) |=> (isr_q[SB_RESET] == $past(isr_q[SB_RESET]) || $past(ev_set[SB_RESET])));

  assert_bit7_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ((isr_q[6:0] & imr_q[6:0]) == 7'd0) |-> !irq);
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
#(
  parameter int STN_BYTES = 6,
  parameter int MC_BYTES  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_hit,
  output logic [DW-1:0]    txpg_q,
  output logic [15:0]      tcnt_q,
  output logic [15:0]      rcnt_q
);
  logic [DW-1:0] pstart_q, pstop_q, bnd_q, curpg_q;
  logic [15:0]   rsa_q;
  logic [DW-1:0] stn_q [STN_BYTES];
  logic [DW-1:0] mc_q  [MC_BYTES];
  logic [STN_BYTES-1:0] stn_hit;
  logic [MC_BYTES-1:0]  mc_hit;

  for (genvar i = 0; i < STN_BYTES; i++) begin : g_stn
    assign stn_hit[i] = (key == K_STN0 + KEY_W'(i));
  end
  for (genvar j = 0; j < MC_BYTES; j++) begin : g_mc
    assign mc_hit[j] = (key == K_MC0 + KEY_W'(j));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pstart_q <= '0; pstop_q <= '0; bnd_q <= '0; curpg_q <= '0;
      txpg_q <= '0; tcnt_q <= '0; rsa_q <= '0; rcnt_q <= '0;
      for (int i = 0; i < STN_BYTES; i++) stn_q[i] <= '0;
      for (int j = 0; j < MC_BYTES; j++) mc_q[j] <= '0;
    end else if (wr_en) begin
      case (key)
        K_PSTART: pstart_q <= wdata;
        K_PSTOP:  pstop_q  <= wdata;
        K_BND:    bnd_q    <= wdata;
        K_TXPG:   txpg_q   <= wdata;
        K_TCNT_L: tcnt_q   <= f_merge_byte(tcnt_q, wdata, 1'b0);
        K_TCNT_H: tcnt_q   <= f_merge_byte(tcnt_q, wdata, 1'b1);
        K_RSA_L:  rsa_q    <= f_merge_byte(rsa_q, wdata, 1'b0);
        K_RSA_H:  rsa_q    <= f_merge_byte(rsa_q, wdata, 1'b1);
        K_RCNT_L: rcnt_q   <= f_merge_byte(rcnt_q, wdata, 1'b0);
        K_RCNT_H: rcnt_q   <= f_merge_byte(rcnt_q, wdata, 1'b1);
        K_CURPG:  curpg_q  <= wdata;
        default: ;
      endcase
      for (int i = 0; i < STN_BYTES; i++) if (stn_hit[i]) stn_q[i] <= wdata;
      for (int j = 0; j < MC_BYTES; j++)  if (mc_hit[j])  mc_q[j]  <= wdata;
    end
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (key)
      K_BND:     rd_data = bnd_q;
      K_RSA_L:   rd_data = rsa_q[7:0];
      K_RSA_H:   rd_data = rsa_q[15:8];
      K_CURPG:   rd_data = curpg_q;
      K_RPSTART: rd_data = pstart_q;
      K_RPSTOP:  rd_data = pstop_q;
      default:   rd_hit  = 1'b0;
    endcase
    for (int i = 0; i < STN_BYTES; i++) if (stn_hit[i]) begin rd_data = stn_q[i]; rd_hit = 1'b1; end
    for (int j = 0; j < MC_BYTES; j++)  if (mc_hit[j])  begin rd_data = mc_q[j];  rd_hit = 1'b1; end
  end

  assert_tcnt_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key == K_TCNT_L) |=> (tcnt_q[15:8] == $past(tcnt_q[15:8]) && tcnt_q[7:0] == $past(wdata)));

  assert_rsa_merge_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key == K_RSA_H) |=> (rsa_q[7:0] == $past(rsa_q[7:0]) && rsa_q[15:8] == $past(wdata)));
endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_pkg::*;
#(
  parameter int STN_BYTES = 6,
  parameter int MC_BYTES  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_wr,
  input  logic [3:0]   host_addr,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  input  logic [7:0]   rx_events,
  output logic         irq,
  output logic         send_req,
  output logic [7:0]   tx_page,
  output logic [15:0]  tx_count
);
  logic [DW-1:0]    cmd_q, tsr_q, isr_q, imr_q, cfg_rdata;
  logic [KEY_W-1:0] key;
  logic             wr_cmd, wr_key, cfg_hit;
  logic             run_ev, dma_done_ev, tx_done_ev;
  logic [15:0]      rcnt_q;

  assign key    = f_key(cmd_q[7:6], host_addr);
  assign wr_cmd = host_wr && (host_addr == '0);
  assign wr_key = host_wr && (host_addr != '0);

  nic_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(wr_cmd), .wdata(host_wdata),
    .rcnt_zero(rcnt_q == 16'd0), .cmd_q(cmd_q), .tsr_q(tsr_q),
    .send_req(send_req), .run_ev(run_ev), .dma_done_ev(dma_done_ev),
    .tx_done_ev(tx_done_ev)
  );

  nic_status_irq u_stat (
    .clk(clk), .rst(rst),
    .stat_wr(wr_key && key == K_STAT), .mask_wr(wr_key && key == K_MASK),
    .wdata(host_wdata), .run_ev(run_ev), .dma_done_ev(dma_done_ev),
    .tx_done_ev(tx_done_ev), .ev_set(rx_events),
    .isr_q(isr_q), .imr_q(imr_q), .irq(irq)
  );

  nic_cfg_regs #(.STN_BYTES(STN_BYTES), .MC_BYTES(MC_BYTES)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_key), .key(key), .wdata(host_wdata),
    .rd_data(cfg_rdata), .rd_hit(cfg_hit), .txpg_q(tx_page),
    .tcnt_q(tx_count), .rcnt_q(rcnt_q)
  );

  always_comb begin
    if (host_addr == '0)        host_rdata = cmd_q;
    else if (key == K_STAT)     host_rdata = isr_q;
    else if (key == K_TXPG)     host_rdata = tsr_q;
    else if (cfg_hit)           host_rdata = cfg_rdata;
    else                        host_rdata = '0;
  end

  assert_zero_len_dma_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !host_wdata[CB_STOP] && (host_wdata[CB_RREAD] || host_wdata[CB_RWRITE])
      && rcnt_q == 16'd0) |=> isr_q[SB_DMA]);

  assert_reset_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !host_wdata[CB_STOP] && !rx_events[SB_RESET]) |=> !isr_q[SB_RESET]);

  assert_page3_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[7:6] == 2'b11 && host_addr != '0) |-> host_rdata == 8'h00);
endmodule

// File: tb/tb_nic_regfile.sv
module tb_nic_regfile;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] rx_events = '0;
  logic [7:0] host_rdata;
  logic irq, send_req;
  logic [7:0] tx_page;
  logic [15:0] tx_count;

  always #10 clk = ~clk;

  nic_regfile dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_events(rx_events),
    .irq(irq), .send_req(send_req), .tx_page(tx_page), .tx_count(tx_count)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cmd, m_isr, m_imr, m_tsr, m_pstart, m_pstop, m_bnd, m_txpg, m_curpg;
  logic [15:0] m_tcnt, m_rsa, m_rcnt;
  logic [7:0] m_stn [6];
  logic [7:0] m_mc [8];
  bit m_send;

  task automatic model_reset();
    m_cmd = 8'h01; m_isr = 8'h80; m_imr = 0; m_tsr = 0; m_pstart = 0; m_pstop = 0;
    m_bnd = 0; m_txpg = 0; m_curpg = 0; m_tcnt = 0; m_rsa = 0; m_rcnt = 0; m_send = 0;
    foreach (m_stn[i]) m_stn[i] = 0;
    foreach (m_mc[i]) m_mc[i] = 0;
  endtask

  task automatic model_clock(bit r, bit wr, logic [3:0] a, logic [7:0] d, logic [7:0] ev);
    logic [7:0] nisr;
    int k;
    if (r) begin model_reset(); return; end
    m_send = 0;
    nisr = m_isr;
    if (wr && a == 0) begin
      m_cmd = d;
      if (!d[0]) begin
        nisr[7] = 1'b0;
        if ((d[3] || d[4]) && m_rcnt == 0) nisr[6] = 1'b1;
        if (d[2]) begin
          m_send = 1; m_tsr = 8'h01; nisr[1] = 1'b1; m_cmd[2] = 1'b0;
        end
      end
    end else if (wr) begin
      k = int'(m_cmd[7:6]) * 16 + int'(a);
      if (k == 1) m_pstart = d;
      else if (k == 2) m_pstop = d;
      else if (k == 3) m_bnd = d;
      else if (k == 4) m_txpg = d;
      else if (k == 5) m_tcnt[7:0] = d;
      else if (k == 6) m_tcnt[15:8] = d;
      else if (k == 7) nisr = nisr & ~(d & 8'h7F);
      else if (k == 8) m_rsa[7:0] = d;
      else if (k == 9) m_rsa[15:8] = d;
      else if (k == 10) m_rcnt[7:0] = d;
      else if (k == 11) m_rcnt[15:8] = d;
      else if (k == 15) m_imr = d;
      else if (k >= 17 && k <= 22) m_stn[k-17] = d;
      else if (k == 23) m_curpg = d;
      else if (k >= 24 && k <= 31) m_mc[k-24] = d;
    end
    m_isr = nisr | ev;
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    int k;
    if (a == 0) return m_cmd;
    k = int'(m_cmd[7:6]) * 16 + int'(a);
    if (k == 3) return m_bnd;
    if (k == 4) return m_tsr;
    if (k == 7) return m_isr;
    if (k == 8) return m_rsa[7:0];
    if (k == 9) return m_rsa[15:8];
    if (k >= 17 && k <= 22) return m_stn[k-17];
    if (k == 23) return m_curpg;
    if (k >= 24 && k <= 31) return m_mc[k-24];
    if (k == 33) return m_pstart;
    if (k == 34) return m_pstop;
    return 8'h00;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive after negedge, update model at posedge, compare at next negedge
  task automatic step(bit r, bit wr, logic [3:0] a, logic [7:0] d, logic [7:0] ev, string tag);
    rst = r; host_wr = wr; host_addr = a; host_wdata = d; rx_events = ev;
    @(posedge clk);
    model_clock(r, wr, a, d, ev);
    @(negedge clk);
    host_wr = 0; rx_events = 0;
    chk(tag, "rdata", {8'h0, host_rdata}, {8'h0, model_read(a)});
    chk(tag, "irq", {15'h0, irq}, {15'h0, ((m_isr & m_imr & 8'h7F) != 0)});
    chk(tag, "send_req", {15'h0, send_req}, {15'h0, m_send});
    chk(tag, "tx_page", {8'h0, tx_page}, {8'h0, m_txpg});
    chk(tag, "tx_count", tx_count, m_tcnt);
  endtask

  task automatic wr_(logic [3:0] a, logic [7:0] d, string tag);
    step(0, 1, a, d, 8'h00, tag);
  endtask
  task automatic rd_(logic [3:0] a, string tag);
    step(0, 0, a, 8'h00, 8'h00, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
    // R1 reset state across page 0
    for (int a = 0; a < 16; a++) rd_(4'(a), "R1");

    // R8 ring pointers and transmit page
    wr_(1, 8'h40, "R8"); wr_(2, 8'h80, "R8"); wr_(3, 8'h4C, "R8"); wr_(4, 8'h46, "R8");
    rd_(1, "R8"); rd_(2, "R8"); rd_(3, "R8");
    // R7 byte-wise 16-bit registers
    wr_(5, 8'h3C, "R7"); wr_(6, 8'h05, "R7"); wr_(5, 8'h7F, "R7");
    wr_(8, 8'h12, "R7"); wr_(9, 8'h34, "R7"); wr_(8, 8'h56, "R7");
    rd_(8, "R7"); rd_(9, "R7");
    // page 2 read-back; writes there ignored (R2)
    wr_(0, 8'h81, "R8"); rd_(1, "R8"); rd_(2, "R8");
    wr_(1, 8'hFF, "R2"); rd_(1, "R2");
    // R9 page 1
    wr_(0, 8'h41, "R9");
    for (int a = 1; a < 16; a++) wr_(4'(a), 8'(8'h10 + a), "R9");
    for (int a = 1; a < 16; a++) rd_(4'(a), "R9");
    // R2 page 3 is empty and inert
    wr_(0, 8'hC1, "R2");
    for (int a = 1; a < 16; a++) wr_(4'(a), 8'hEE, "R2");
    for (int a = 0; a < 16; a++) rd_(4'(a), "R2");
    wr_(0, 8'h41, "R2");
    for (int a = 1; a < 16; a++) rd_(4'(a), "R2");
    // R3 mask all, only bit 7 pending -> irq low
    wr_(0, 8'h01, "R3"); wr_(15, 8'hFF, "R3"); rd_(7, "R3");
    // R5 start with remote read and zero count
    wr_(0, 8'h0A, "R5"); rd_(7, "R5");
    // R4 write-1-to-clear
    wr_(7, 8'h40, "R4"); rd_(7, "R4");
    // R5 non-zero count: no completion
    wr_(10, 8'h04, "R5"); wr_(0, 8'h12, "R5"); rd_(7, "R5");
    // R4 same-cycle clear and event: set wins
    step(0, 1, 7, 8'h01, 8'h01, "R4"); rd_(7, "R4");
    wr_(7, 8'hFF, "R4"); rd_(7, "R4");
    // R3 bit 7 event never raises irq
    step(0, 0, 7, 8'h00, 8'h80, "R3"); rd_(7, "R3");
    wr_(15, 8'h00, "R3"); step(0, 0, 7, 8'h00, 8'h04, "R3"); wr_(15, 8'h04, "R3");
    wr_(7, 8'h04, "R3");
    // R6 transmit command
    wr_(0, 8'h26, "R6"); rd_(0, "R6"); rd_(4, "R6"); rd_(7, "R6");
    wr_(0, 8'h05, "R6"); rd_(0, "R6");
    // R5 command clears reset flag while the event sets it: set wins
    step(0, 1, 0, 8'h22, 8'h80, "R5"); rd_(7, "R5");

    // randomized mix against the model
    step(1, 0, 0, 0, 0, "R1");
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] a;
      logic [7:0] d, ev;
      bit w;
      a  = 4'($urandom_range(0, 15));
      d  = 8'($urandom);
      w  = ($urandom_range(0, 1) == 1);
      ev = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
      if (w && a == 0 && $urandom_range(0, 3) != 0) d[0] = 1'b0;
      step(0, w, a, d, ev, "R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule